// File: doc/BRIEF.md
# Serial port register and interrupt front end

This block is the processor-facing side of a serial port. A 32-bit bus addresses a small window of word registers by word index (byte offset divided by four). Received bytes come in over a byte-wide valid/ready handshake and are queued in a 16-entry receive FIFO. Bytes to be sent leave as a one-cycle strobe carrying the data byte. The transmitter beyond that strobe is taken to be always ready and idle.

Software reads a combined status/data word in one of two forms. The peek form leaves the FIFO alone. The popping form removes the oldest byte. A raw interrupt register, a mask register and the masked result drive one level-sensitive interrupt line. One quirk is kept on purpose: the first acknowledge written after a transmit write cannot clear the transmit-done bit.

Top module: `serport_regfile`

## Requirements
- R1: After synchronous reset the receive control word (index 2, byte 0x08) reads 0x00010000. Every other stored word, the raw interrupt word and the FIFO are zero, and both rx_ready and irq are low.
- R2: A read of the status/data word returns a fixed layout. Bits 7:0 hold the oldest queued byte, or 0 when the FIFO is empty. Bit 16 is 1 when the FIFO is not empty. Bits 22 and 24 are always 1. All other bits are 0.
- R3: Reading index 9 (byte 0x24) leaves the FIFO unchanged. Reading index 8 (byte 0x20) removes the oldest byte, and does nothing to the FIFO when it is empty.
- R4: The FIFO holds 16 bytes and returns them in arrival order. While it is full, rx_ready is low and a presented byte is not taken.
- R5: rx_ready is low whenever bit 3 of the receive control word is 0.
- R6: Bit 3 of the raw interrupt word (index 13, byte 0x34) is 1 exactly when the FIFO is not empty.
- R7: A write to index 7 (byte 0x1C) has four effects. It gives one tx_strobe cycle, one cycle after the write, with tx_byte equal to the written bits 7:0. The value is stored and reads back at index 7. Raw interrupt bits 0 and 1 are set. A pending-transmit flag is armed.
- R8: A write to index 12 (byte 0x30) stores the value and clears the raw interrupt bits written as 1. If the pending-transmit flag is armed, bit 0 is first removed from the value and the flag is cleared.
- R9: Index 14 (byte 0x38) reads raw AND mask, with the mask at index 11 (byte 0x2C). irq is high exactly when that result is non-zero.
- R10: The remaining indices below 15 are plain read/write storage. Writes to indices 8, 9, 13 and 14 are ignored. Index 15 (byte 0x3C) reads 0 and ignores writes.
- R11: A byte that is received in the same cycle as a popping read leaves the FIFO occupancy unchanged. The byte is appended behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Byte sent with tx_strobe |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the bus carries at most one access per cycle, so a transmit write and an acknowledge never fall in the same cycle. The stimulus holds each access for exactly one clock and keeps bus_sel low between accesses. Incoming bytes are assumed to be offered through the handshake, and the bench presents a byte while rx_ready is low only on purpose, to show that it is refused. The bench also lines up a receive with a popping read in one cycle to exercise the shared-occupancy case.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int WIDX_W   = 4;
    localparam int WIN_WORDS = 15;

    typedef logic [WIDX_W-1:0] widx_t;

    localparam widx_t IX_TXCTL  = 4'd0;
    localparam widx_t IX_TXDMA  = 4'd1;
    localparam widx_t IX_RXCTL  = 4'd2;
    localparam widx_t IX_DOUT   = 4'd7;
    localparam widx_t IX_POP    = 4'd8;
    localparam widx_t IX_PEEK   = 4'd9;
    localparam widx_t IX_MASK   = 4'd11;
    localparam widx_t IX_ACK    = 4'd12;
    localparam widx_t IX_RAW    = 4'd13;
    localparam widx_t IX_MASKED = 4'd14;

    localparam int ST_AVAIL = 16;
    localparam int ST_IDLE  = 22;
    localparam int ST_READY = 24;
    localparam int RXEN_BIT = 3;
    localparam int RXIRQ_BIT = 3;

    localparam logic [WORD_W-1:0] RXCTL_INIT = 32'h0001_0000;

    typedef struct packed {
        logic  rd;
        logic  wr;
        logic  in_win;
        widx_t idx;
    } bus_op_t;

    function automatic bit is_storage(int idx);
        return !(idx == int'(IX_POP) || idx == int'(IX_PEEK) ||
                 idx == int'(IX_RAW) || idx == int'(IX_MASKED));
    endfunction

    function automatic logic [WORD_W-1:0] init_val(int idx);
        return (idx == int'(IX_RXCTL)) ? RXCTL_INIT : '0;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(logic [BYTE_W-1:0] head, logic avail);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BYTE_W-1:0] = head;
        w[ST_AVAIL]   = avail;
        w[ST_IDLE]    = 1'b1;
        w[ST_READY]   = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/serport_rxq.sv
module serport_rxq #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop_req && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_push_full_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop_req) |=> $stable(count));

    assert_push_pop_even_R11: assert property (@(posedge clk) disable iff (rst)
        (push && pop_req && !empty) |=> $stable(count));

endmodule

// File: rtl/serport_irq.sv
module serport_irq #(
    parameter int W      = 32,
    parameter int RX_BIT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dout_wr,
    input  logic         ack_wr,
    input  logic [W-1:0] wdata,
    input  logic         rx_nonempty,
    input  logic [W-1:0] mask,
    output logic [W-1:0] raw,
    output logic [W-1:0] masked,
    output logic [W-1:0] ack_val,
    output logic         irq_o
);
    localparam logic [W-1:0] RX_M   = W'(1) << RX_BIT;
    localparam logic [W-1:0] TX_SET = W'(3);
    localparam logic [W-1:0] TX_B0  = W'(1);

    logic [W-1:0] raw_q;
    logic         pend_q;

    assign ack_val = pend_q ? (wdata & ~TX_B0) : wdata;
    assign raw     = (raw_q & ~RX_M) | (rx_nonempty ? RX_M : '0);
    assign masked  = raw & mask;
    assign irq_o   = |masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            pend_q <= 1'b0;
        end else if (dout_wr) begin
            raw_q  <= raw_q | TX_SET;
            pend_q <= 1'b1;
        end else if (ack_wr) begin
            raw_q  <= raw_q & ~ack_val;
            pend_q <= 1'b0;
        end
    end

    assert_dout_sets_R7: assert property (@(posedge clk) disable iff (rst)
        dout_wr |=> (raw_q[1:0] == 2'b11) && pend_q);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !pend_q) |=> ((raw_q & ~RX_M & $past(wdata)) == '0));

    assert_ack_quirk_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && pend_q) |=> (raw_q[0] == $past(raw_q[0])) && !pend_q);

endmodule

// File: rtl/serport_regfile.sv
module serport_regfile
    import serport_pkg::*;
#(
    parameter int RX_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [WIDX_W-1:0]    bus_word,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_data,
    output logic                 rx_ready,
    output logic                 tx_strobe,
    output logic [BYTE_W-1:0]    tx_byte,
    output logic                 irq
);
    bus_op_t           op;
    logic [WORD_W-1:0] word_q [WIN_WORDS];
    logic [WORD_W-1:0] raw, masked, ack_val;
    logic [BYTE_W-1:0] head;
    logic              empty, full, push, pop_req;
    logic              dout_wr, ack_wr;

    always_comb begin
        op.rd     = bus_sel && !bus_wr;
        op.wr     = bus_sel && bus_wr;
        op.idx    = bus_word;
        op.in_win = (int'(bus_word) < WIN_WORDS);
    end

    assign dout_wr  = op.wr && (op.idx == IX_DOUT);
    assign ack_wr   = op.wr && (op.idx == IX_ACK);
    assign pop_req  = op.rd && (op.idx == IX_POP);
    assign rx_ready = word_q[IX_RXCTL][RXEN_BIT] && !full;
    assign push     = rx_valid && rx_ready;

    for (genvar i = 0; i < WIN_WORDS; i++) begin : g_word
        if (is_storage(i)) begin : g_store
            logic [WORD_W-1:0] nxt;
            if (i == int'(IX_ACK)) begin : g_ack
                assign nxt = ack_val;
            end else begin : g_plain
                assign nxt = bus_wdata;
            end
            always_ff @(posedge clk) begin
                if (rst)
                    word_q[i] <= init_val(i);
                else if (op.wr && (op.idx == widx_t'(i)))
                    word_q[i] <= nxt;
            end
        end else begin : g_none
            assign word_q[i] = '0;
        end
    end

    serport_rxq #(.DEPTH(RX_DEPTH), .DW(BYTE_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (rx_data),
        .pop_req   (pop_req),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    serport_irq #(.W(WORD_W), .RX_BIT(RXIRQ_BIT)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .dout_wr     (dout_wr),
        .ack_wr      (ack_wr),
        .wdata       (bus_wdata),
        .rx_nonempty (!empty),
        .mask        (word_q[IX_MASK]),
        .raw         (raw),
        .masked      (masked),
        .ack_val     (ack_val),
        .irq_o       (irq)
    );

    always_comb begin
        if (!op.in_win)
            bus_rdata = '0;
        else begin
            case (op.idx)
                IX_POP, IX_PEEK: bus_rdata = status_word(head, !empty);
                IX_RAW:          bus_rdata = raw;
                IX_MASKED:       bus_rdata = masked;
                default:         bus_rdata = word_q[op.idx];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            tx_strobe <= dout_wr;
            if (dout_wr) tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        dout_wr |=> tx_strobe && (tx_byte == $past(bus_wdata[BYTE_W-1:0])));

    assert_rx_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !word_q[IX_RXCTL][RXEN_BIT] |-> !rx_ready);

    assert_irq_line_R9: assert property (@(posedge clk) disable iff (rst)
        (raw & word_q[IX_MASK]) == '0 |-> !irq);

endmodule

// File: tb/serport_regfile_tb_top.sv
`timescale 1ns/1ps
module serport_regfile_tb_top;
    import serport_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0, tx_byte;
    logic        tx_strobe, irq;

    int checks = 0, fails = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [7:0]  tx_q  [$];
    logic [7:0]  model [$];
    bit          rx_en = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    serport_regfile dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    // Monitor: compare read data and transmit strobes against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_sel && !bus_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL read with no expected item: got %h exp none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s word %0d: got %h exp %h", t, bus_word, bus_rdata, e);
                end
            end
        end
        if (!rst && tx_strobe) begin
            checks++;
            if (tx_q.size() == 0) begin
                fails++;
                $display("FAIL R7 tx strobe unexpected: got %h exp none", tx_byte);
            end else begin
                logic [7:0] eb;
                eb = tx_q.pop_front();
                if (tx_byte !== eb) begin
                    fails++;
                    $display("FAIL R7 tx byte: got %h exp %h", tx_byte, eb);
                end
            end
        end
    end

    function automatic logic [31:0] stat_exp();
        return (model.size() != 0) ? (32'h0141_0000 | {24'd0, model[0]}) : 32'h0140_0000;
    endfunction

    task automatic chk(input logic got, input logic exp, input string t);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b exp %b", t, got, exp);
        end
    endtask

    task automatic bus_write(input int idx, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_word = 4'(idx); bus_wdata = d;
        if (idx == 7) tx_q.push_back(d[7:0]);
        if (idx == 2) rx_en = d[3];
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input int idx, input logic [31:0] e, input string t);
        bus_sel = 1; bus_wr = 0; bus_word = 4'(idx);
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic stat_read(input bit pop, input string t);
        logic [31:0] e;
        e = stat_exp();
        if (pop && model.size() != 0) void'(model.pop_front());
        bus_read(pop ? 8 : 9, e, t);
    endtask

    task automatic rx_send(input logic [7:0] b);
        rx_valid = 1; rx_data = b;
        if (rx_en && model.size() < 16) model.push_back(b);
        @(posedge clk); #1;
        rx_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        chk(rx_ready, 1'b0, "R1 rx_ready after reset");
        chk(irq, 1'b0, "R1 irq after reset");
        @(posedge clk); #1;
        bus_read(2, 32'h0001_0000, "R1 rxctl reset");
        bus_read(11, 32'h0, "R1 mask reset");
        bus_read(13, 32'h0, "R1 raw reset");
        bus_read(7, 32'h0, "R1 dout reset");
        stat_read(0, "R2 empty status");

        // receiver disabled: byte refused
        rx_send(8'hEE);
        stat_read(0, "R5 disabled rx not queued");
        bus_write(2, 32'h8);
        @(negedge clk); chk(rx_ready, 1'b1, "R5 ready when enabled");
        @(posedge clk); #1;

        rx_send(8'hA1); rx_send(8'hB2); rx_send(8'hC3);
        bus_read(13, 32'h8, "R6 raw rx bit set");
        stat_read(0, "R3 peek head");
        stat_read(0, "R3 peek again unchanged");
        stat_read(1, "R2 pop first");
        stat_read(1, "R3 pop second");
        stat_read(0, "R3 peek third");
        stat_read(1, "R3 pop third");
        stat_read(1, "R3 pop on empty");
        stat_read(0, "R3 still empty");
        bus_read(13, 32'h0, "R6 raw rx bit clear");

        // fill to capacity
        for (int i = 0; i < 16; i++) rx_send(8'(8'h40 + i));
        @(negedge clk); chk(rx_ready, 1'b0, "R4 ready low when full");
        @(posedge clk); #1;
        rx_send(8'h99);
        for (int i = 0; i < 17; i++) stat_read(1, "R4 drain order");

        // receive together with popping read
        rx_send(8'h10); rx_send(8'h11);
        rx_valid = 1; rx_data = 8'h12;
        stat_read(1, "R11 pop with receive");
        rx_valid = 0;
        model.push_back(8'h12);
        stat_read(1, "R11 second");
        stat_read(1, "R11 appended byte");
        stat_read(0, "R11 empty after");

        // interrupt masking on receive
        bus_write(11, 32'h8);
        @(negedge clk); chk(irq, 1'b0, "R9 irq low with empty fifo");
        @(posedge clk); #1;
        rx_send(8'h55);
        @(negedge clk); chk(irq, 1'b1, "R9 irq on masked rx");
        @(posedge clk); #1;
        bus_read(14, 32'h8, "R9 masked word");
        stat_read(1, "R3 pop 55");
        @(negedge clk); chk(irq, 1'b0, "R9 irq clears after pop");
        @(posedge clk); #1;

        // transmit and acknowledge quirk
        bus_write(7, 32'h1234_5678);
        bus_read(7, 32'h1234_5678, "R7 dout stored");
        bus_read(13, 32'h3, "R7 raw tx bits");
        bus_write(11, 32'h3);
        @(negedge clk); chk(irq, 1'b1, "R9 irq on tx");
        @(posedge clk); #1;
        bus_write(12, 32'h3);
        bus_read(13, 32'h1, "R8 first ack keeps bit0");
        bus_read(12, 32'h2, "R8 stored ack value");
        @(negedge clk); chk(irq, 1'b1, "R8 irq still high");
        @(posedge clk); #1;
        bus_write(12, 32'h1);
        bus_read(13, 32'h0, "R8 second ack clears");
        bus_read(12, 32'h1, "R8 stored second ack");
        bus_read(14, 32'h0, "R9 masked zero");
        @(negedge clk); chk(irq, 1'b0, "R8 irq low");
        @(posedge clk); #1;

        // plain storage and ignored writes
        bus_write(0, 32'hDEAD_BEEF);
        bus_write(1, 32'h0000_0001);
        bus_write(10, 32'hA5A5_5A5A);
        bus_read(0, 32'hDEAD_BEEF, "R10 word0 storage");
        bus_read(1, 32'h0000_0001, "R10 word1 storage");
        bus_read(10, 32'hA5A5_5A5A, "R10 word10 storage");
        bus_write(13, 32'hFF);
        bus_write(14, 32'hFF);
        bus_read(13, 32'h0, "R10 raw write ignored");
        bus_read(14, 32'h0, "R10 masked write ignored");
        bus_write(15, 32'hFFFF_FFFF);
        bus_read(15, 32'h0, "R10 outside window");
        bus_write(9, 32'hFFFF_FFFF);
        stat_read(0, "R10 status write ignored");
        bus_write(2, 32'h0);
        @(negedge clk); chk(rx_ready, 1'b0, "R5 ready low when disabled");
        @(posedge clk); #1;

        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0 || tx_q.size() != 0) begin
            fails++;
            $display("FAIL R7 leftover items: got %0d exp 0", exp_q.size() + tx_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule